// File: doc/BRIEF.md
# Trap Entry and Return Sequencer

This block carries out the hardware steps a processor takes when control passes into the kernel because of a software trap, a fault or an external interrupt. A start pulse captures the trap vector, the kind of trap and the interrupted context. The block then fetches a 64-bit gate from a 16-entry descriptor table whose base address is an input. It checks privilege for software traps. It switches to the kernel stack given by a task-state stack pointer and segment pair, and writes the interrupted context as five 32-bit words. The result is the kernel context: the code segment and instruction pointer from the gate, the new stack, privilege level 0, and the flags with the interrupt-enable and single-step bits cleared.

The same block also runs the return sequence. Starting from the current stack pointer, it reads the five saved words back in the reverse order and presents the restored context. Every memory access uses one request/acknowledge port, and the port waits for as many cycles as the memory needs.

Top module: `trap_seq`

## Requirements
- R1: On entry the block makes two reads. The first is at `idtBase + 8*vector` and its word is the target instruction pointer. The second is at that address plus 4; in its word, bits [15:0] are the code selector and bits [17:16] are the gate privilege level.
- R2: For a software trap (`trapKind` = 0), entry goes ahead only when `curCpl` is less than or equal to the gate privilege level. For a fault (`trapKind` = 1) or an external interrupt (`trapKind` = 2), the privilege check is skipped.
- R3: A failed privilege check raises `done` and `gpFault` together for one cycle and performs no memory write. All `new*` outputs keep their previous values.
- R4: An entry writes five words at `tssEsp0-4`, `-8`, `-12`, `-16` and `-20`, in that order. The words are the old stack segment (zero-extended), the old stack pointer, the old flags, the old code segment (zero-extended) and the old instruction pointer.
- R5: Each access holds `memReq` with a stable address, write enable and write data until the cycle in which `memAck` is high. Results are correct for any acknowledge latency.
- R6: A successful entry presents the following: `newCs` and `newEip` from the gate, `newSs` = `tssSs0`, `newEsp` = `tssEsp0-20`, `newCpl` = 0, and `newFlags` = old flags with bits 9 and 8 cleared.
- R7: A return (`isReturn` = 1) reads `curEsp`, `+4`, `+8`, `+12` and `+16` as instruction pointer, code segment, flags, stack pointer and stack segment. It performs no write and presents those values, with `newCpl` = low two bits of the popped code segment.
- R8: `busy` is high from the cycle after an accepted start until `done`, and `done` is a one-cycle pulse. New context values are valid in the `done` cycle, and a `start` while `busy` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sequence when idle |
| isReturn | input | 1 | 1 = return sequence, 0 = entry |
| trapKind | input | 2 | 0 software trap, 1 fault, 2 external interrupt |
| vector | input | 4 | Gate index |
| idtBase | input | 32 | Descriptor table base address |
| curCpl | input | 2 | Current privilege level |
| curCs | input | 16 | Current code segment |
| curEip | input | 32 | Current instruction pointer |
| curFlags | input | 32 | Current flags |
| curEsp | input | 32 | Current stack pointer |
| curSs | input | 16 | Current stack segment |
| tssEsp0 | input | 32 | Kernel stack pointer |
| tssSs0 | input | 16 | Kernel stack segment |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Write enable for the access |
| memAddr | output | 32 | Byte address |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid with `memAck` |
| memAck | input | 1 | Access complete |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| gpFault | output | 1 | Privilege failure, with `done` |
| newCs | output | 16 | Resulting code segment |
| newEip | output | 32 | Resulting instruction pointer |
| newFlags | output | 32 | Resulting flags |
| newEsp | output | 32 | Resulting stack pointer |
| newSs | output | 16 | Resulting stack segment |
| newCpl | output | 2 | Resulting privilege level |

## Verification
The assertions check the following on every cycle:
- request stability until acknowledge;
- the absence of writes during a return;
- the unchanged context on a privilege fault;
- the single-cycle `done` pulse;
- the kernel privilege level and cleared flag bits after every successful entry.

Only the directed scenarios can show the exact read and write addresses and the order of pushed words. The same holds for the gate field decoding, the per-kind privilege decisions at the equality boundary, the round trip of entry followed by return, and the rejection of a start during a busy sequence.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_GATE_LO, ST_GATE_HI, ST_CHECK, ST_PUSH, ST_POP, ST_DONE, ST_FAULT
  } seqState_e;

  typedef enum logic [1:0] {
    KIND_SOFT  = 2'd0,
    KIND_FAULT = 2'd1,
    KIND_IRQ   = 2'd2,
    KIND_RSVD  = 2'd3
  } trapKind_e;

  typedef enum logic [1:0] {
    ASEL_GATE_LO, ASEL_GATE_HI, ASEL_PUSH, ASEL_POP
  } addrSel_e;

  typedef struct packed {
    logic     capture;
    logic     gateLo;
    logic     gateHi;
    logic     pushStep;
    logic     popStep;
    logic     commitEntry;
    logic     commitReturn;
    addrSel_e addrSel;
  } dpCtl_t;

endpackage

// File: rtl/trap_seq_ctrl.sv
module trap_seq_ctrl
  import trap_seq_pkg::*;
#(
  parameter int FRAME_WORDS = 5,
  localparam int IDX_W = $clog2(FRAME_WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             isReturn,
  input  logic             privOk,
  input  logic             memAck,
  output dpCtl_t           ctl,
  output logic [IDX_W-1:0] wordIdx,
  output logic             memReq,
  output logic             memWe,
  output logic             busy,
  output logic             done,
  output logic             gpFault
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_WORDS - 1);

  seqState_e        state, nextState;
  logic [IDX_W-1:0] nextIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wordIdx <= '0;
    end else begin
      state   <= nextState;
      wordIdx <= nextIdx;
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.addrSel = ASEL_GATE_LO;
    nextState   = state;
    nextIdx     = wordIdx;
    memReq      = 1'b0;
    memWe       = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.capture = 1'b1;
          nextIdx     = '0;
          nextState   = isReturn ? ST_POP : ST_GATE_LO;
        end
      end
      ST_GATE_LO: begin
        memReq = 1'b1;
        if (memAck) begin
          ctl.gateLo = 1'b1;
          nextState  = ST_GATE_HI;
        end
      end
      ST_GATE_HI: begin
        memReq      = 1'b1;
        ctl.addrSel = ASEL_GATE_HI;
        if (memAck) begin
          ctl.gateHi = 1'b1;
          nextState  = ST_CHECK;
        end
      end
      ST_CHECK: begin
        nextIdx   = '0;
        nextState = privOk ? ST_PUSH : ST_FAULT;
      end
      ST_PUSH: begin
        memReq      = 1'b1;
        memWe       = 1'b1;
        ctl.addrSel = ASEL_PUSH;
        if (memAck) begin
          ctl.pushStep = 1'b1;
          if (wordIdx == LAST_IDX) begin
            ctl.commitEntry = 1'b1;
            nextState       = ST_DONE;
          end else begin
            nextIdx = wordIdx + 1'b1;
          end
        end
      end
      ST_POP: begin
        memReq      = 1'b1;
        ctl.addrSel = ASEL_POP;
        if (memAck) begin
          ctl.popStep = 1'b1;
          if (wordIdx == LAST_IDX) begin
            ctl.commitReturn = 1'b1;
            nextState        = ST_DONE;
          end else begin
            nextIdx = wordIdx + 1'b1;
          end
        end
      end
      ST_DONE:  nextState = ST_IDLE;
      ST_FAULT: nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_DONE) || (state == ST_FAULT);
  assign gpFault = (state == ST_FAULT);

endmodule

// File: rtl/trap_seq_dp.sv
module trap_seq_dp
  import trap_seq_pkg::*;
#(
  parameter int          DATA_W      = 32,
  parameter int          SEL_W       = 16,
  parameter int          VEC_W       = 4,
  parameter int          FRAME_WORDS = 5,
  parameter logic [31:0] FLAG_CLEAR  = 32'h0000_0300,
  localparam int IDX_W = $clog2(FRAME_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic              isReturn,
  input  logic [1:0]        trapKind,
  input  logic [VEC_W-1:0]  vector,
  input  logic [DATA_W-1:0] idtBase,
  input  logic [1:0]        curCpl,
  input  logic [SEL_W-1:0]  curCs,
  input  logic [DATA_W-1:0] curEip,
  input  logic [DATA_W-1:0] curFlags,
  input  logic [DATA_W-1:0] curEsp,
  input  logic [SEL_W-1:0]  curSs,
  input  logic [DATA_W-1:0] tssEsp0,
  input  logic [SEL_W-1:0]  tssSs0,
  input  logic [DATA_W-1:0] memRdata,
  output logic              privOk,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [SEL_W-1:0]  newCs,
  output logic [DATA_W-1:0] newEip,
  output logic [DATA_W-1:0] newFlags,
  output logic [DATA_W-1:0] newEsp,
  output logic [SEL_W-1:0]  newSs,
  output logic [1:0]        newCpl
);

  localparam int                WORD_BYTES = DATA_W / 8;
  localparam int                GATE_SHIFT = $clog2(2 * WORD_BYTES);
  localparam logic [DATA_W-1:0] STEP       = DATA_W'(WORD_BYTES);
  localparam int                PAD_W      = DATA_W - SEL_W;

  trapKind_e         kindQ;
  logic [VEC_W-1:0]  vecQ;
  logic [DATA_W-1:0] baseQ, eipQ, flagsQ, espQ, sp;
  logic [SEL_W-1:0]  csQ, ssQ, ss0Q;
  logic [1:0]        cplQ;
  logic [DATA_W-1:0] gateEip;
  logic [SEL_W-1:0]  gateSel;
  logic [1:0]        gateDpl;
  logic [DATA_W-1:0] popEip, popFlags, popEsp;
  logic [SEL_W-1:0]  popCs;
  logic [DATA_W-1:0] gateAddr;

  assign gateAddr = baseQ + (DATA_W'(vecQ) << GATE_SHIFT);
  assign privOk   = (kindQ != KIND_SOFT) || (cplQ <= gateDpl);

  always_comb begin
    unique case (ctl.addrSel)
      ASEL_GATE_LO: memAddr = gateAddr;
      ASEL_GATE_HI: memAddr = gateAddr + STEP;
      ASEL_PUSH:    memAddr = sp - STEP;
      default:      memAddr = sp;
    endcase
  end

  always_comb begin
    unique case (wordIdx)
      IDX_W'(0): memWdata = {{PAD_W{1'b0}}, ssQ};
      IDX_W'(1): memWdata = espQ;
      IDX_W'(2): memWdata = flagsQ;
      IDX_W'(3): memWdata = {{PAD_W{1'b0}}, csQ};
      default:   memWdata = eipQ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kindQ <= KIND_SOFT; vecQ <= '0; baseQ <= '0; cplQ <= '0;
      eipQ <= '0; flagsQ <= '0; espQ <= '0; csQ <= '0; ssQ <= '0; ss0Q <= '0;
      sp <= '0; gateEip <= '0; gateSel <= '0; gateDpl <= '0;
      popEip <= '0; popFlags <= '0; popEsp <= '0; popCs <= '0;
      newCs <= '0; newEip <= '0; newFlags <= '0; newEsp <= '0; newSs <= '0; newCpl <= '0;
    end else begin
      if (ctl.capture) begin
        kindQ  <= trapKind_e'(trapKind);
        vecQ   <= vector;
        baseQ  <= idtBase;
        cplQ   <= curCpl;
        eipQ   <= curEip;
        flagsQ <= curFlags;
        espQ   <= curEsp;
        csQ    <= curCs;
        ssQ    <= curSs;
        ss0Q   <= tssSs0;
        sp     <= isReturn ? curEsp : tssEsp0;
      end
      if (ctl.gateLo) gateEip <= memRdata;
      if (ctl.gateHi) begin
        gateSel <= memRdata[SEL_W-1:0];
        gateDpl <= memRdata[SEL_W+1:SEL_W];
      end
      if (ctl.pushStep) sp <= sp - STEP;
      if (ctl.popStep) begin
        sp <= sp + STEP;
        unique case (wordIdx)
          IDX_W'(0): popEip   <= memRdata;
          IDX_W'(1): popCs    <= memRdata[SEL_W-1:0];
          IDX_W'(2): popFlags <= memRdata;
          IDX_W'(3): popEsp   <= memRdata;
          default: ;
        endcase
      end
      if (ctl.commitEntry) begin
        newCs    <= gateSel;
        newEip   <= gateEip;
        newFlags <= flagsQ & ~FLAG_CLEAR;
        newEsp   <= sp - STEP;
        newSs    <= ss0Q;
        newCpl   <= 2'd0;
      end
      if (ctl.commitReturn) begin
        newCs    <= popCs;
        newEip   <= popEip;
        newFlags <= popFlags;
        newEsp   <= popEsp;
        newSs    <= memRdata[SEL_W-1:0];
        newCpl   <= popCs[1:0];
      end
    end
  end

endmodule

// File: rtl/trap_seq.sv
module trap_seq
  import trap_seq_pkg::*;
#(
  parameter int          FRAME_WORDS = 5,
  parameter logic [31:0] FLAG_CLEAR  = 32'h0000_0300
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        isReturn,
  input  logic [1:0]  trapKind,
  input  logic [3:0]  vector,
  input  logic [31:0] idtBase,
  input  logic [1:0]  curCpl,
  input  logic [15:0] curCs,
  input  logic [31:0] curEip,
  input  logic [31:0] curFlags,
  input  logic [31:0] curEsp,
  input  logic [15:0] curSs,
  input  logic [31:0] tssEsp0,
  input  logic [15:0] tssSs0,
  output logic        memReq,
  output logic        memWe,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata,
  input  logic [31:0] memRdata,
  input  logic        memAck,
  output logic        busy,
  output logic        done,
  output logic        gpFault,
  output logic [15:0] newCs,
  output logic [31:0] newEip,
  output logic [31:0] newFlags,
  output logic [31:0] newEsp,
  output logic [15:0] newSs,
  output logic [1:0]  newCpl
);

  localparam int IDX_W = $clog2(FRAME_WORDS);

  dpCtl_t           ctl;
  logic [IDX_W-1:0] wordIdx;
  logic             privOk;

  trap_seq_ctrl #(.FRAME_WORDS(FRAME_WORDS)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .isReturn(isReturn),
    .privOk(privOk), .memAck(memAck), .ctl(ctl), .wordIdx(wordIdx),
    .memReq(memReq), .memWe(memWe), .busy(busy), .done(done), .gpFault(gpFault)
  );

  trap_seq_dp #(
    .DATA_W(32), .SEL_W(16), .VEC_W(4),
    .FRAME_WORDS(FRAME_WORDS), .FLAG_CLEAR(FLAG_CLEAR)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wordIdx(wordIdx),
    .isReturn(isReturn), .trapKind(trapKind), .vector(vector), .idtBase(idtBase),
    .curCpl(curCpl), .curCs(curCs), .curEip(curEip), .curFlags(curFlags),
    .curEsp(curEsp), .curSs(curSs), .tssEsp0(tssEsp0), .tssSs0(tssSs0),
    .memRdata(memRdata), .privOk(privOk), .memAddr(memAddr), .memWdata(memWdata),
    .newCs(newCs), .newEip(newEip), .newFlags(newFlags), .newEsp(newEsp),
    .newSs(newSs), .newCpl(newCpl)
  );

endmodule

// File: rtl/trap_seq_chk.sv
module trap_seq_chk #(
  parameter logic [31:0] FLAG_CLEAR = 32'h0000_0300
) (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        isReturn,
  input logic        memReq,
  input logic        memWe,
  input logic [31:0] memAddr,
  input logic [31:0] memWdata,
  input logic        memAck,
  input logic        busy,
  input logic        done,
  input logic        gpFault,
  input logic [15:0] newCs,
  input logic [31:0] newEip,
  input logic [31:0] newFlags,
  input logic [31:0] newEsp,
  input logic [15:0] newSs,
  input logic [1:0]  newCpl
);

  logic retQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              retQ <= 1'b0;
    else if (start && !busy) retQ <= isReturn;
  end

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata));

  assert_no_write_on_return_R7: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe |-> !retQ);

  assert_fault_keeps_ctx_R3: assert property (@(posedge clk) disable iff (!rstN)
    gpFault |-> $stable(newCs) && $stable(newEip) && $stable(newFlags)
                && $stable(newEsp) && $stable(newSs) && $stable(newCpl));

  assert_fault_no_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    gpFault |-> !memReq);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !busy);

  assert_entry_kernel_R6: assert property (@(posedge clk) disable iff (!rstN)
    done && !gpFault && !retQ |-> newCpl == 2'd0 && (newFlags & FLAG_CLEAR) == 32'd0);

endmodule

bind trap_seq trap_seq_chk #(.FLAG_CLEAR(FLAG_CLEAR)) chk_i (.*);

// File: tb/trap_seq_tb_top.sv
`timescale 1ns/1ps
module trap_seq_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0, isReturn = 1'b0;
  logic [1:0]  trapKind = 2'd0;
  logic [3:0]  vector = 4'd0;
  logic [31:0] idtBase = 32'h100;
  logic [1:0]  curCpl = 2'd3;
  logic [15:0] curCs = 16'h001B, curSs = 16'h0023, tssSs0 = 16'h0010;
  logic [31:0] curEip = 32'h4000_1234, curFlags = 32'h0000_0346, curEsp = 32'h7FF0;
  logic [31:0] tssEsp0 = 32'h300;
  logic        memReq, memWe, memAck = 1'b0;
  logic [31:0] memAddr, memWdata, memRdata = 32'd0;
  logic        busy, done, gpFault;
  logic [15:0] newCs, newSs;
  logic [31:0] newEip, newFlags, newEsp;
  logic [1:0]  newCpl;

  int nChecks = 0, nErrors = 0;
  int latency = 0, waitCnt = 0;
  int nWr = 0, nRd = 0, nDone = 0;
  logic [31:0] mem [0:255];
  logic [31:0] wrAddr [0:15];
  logic [31:0] wrData [0:15];
  logic [31:0] rdAddr [0:15];
  logic        sawGp;

  always #2 clk = ~clk;

  trap_seq dut_i (.*);

  // memory model: acknowledge after `latency` idle negedges, one cycle wide
  always @(negedge clk) begin
    if (memAck) memAck = 1'b0;
    else if (memReq) begin
      if (waitCnt >= latency) begin
        memAck   = 1'b1;
        memRdata = mem[memAddr[9:2]];
        waitCnt  = 0;
      end else waitCnt++;
    end
  end

  always @(posedge clk) begin
    if (done) nDone++;
    if (memReq && memAck) begin
      if (memWe) begin
        mem[memAddr[9:2]] = memWdata;
        if (nWr < 16) begin wrAddr[nWr] = memAddr; wrData[nWr] = memWdata; end
        nWr++;
      end else begin
        if (nRd < 16) rdAddr[nRd] = memAddr;
        nRd++;
      end
    end
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clearLogs();
    nWr = 0; nRd = 0; nDone = 0;
  endtask

  task automatic waitDone();
    sawGp = 1'b0;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (done) begin sawGp = gpFault; return; end
    end
    check("R8", "done never seen", 32'd0, 32'd1);
  endtask

  task automatic launch(logic ret, logic [1:0] kind, logic [3:0] vec);
    @(negedge clk);
    clearLogs();
    isReturn = ret; trapKind = kind; vector = vec;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R8", "busy after start", 32'(busy), 32'd1);
  endtask

  task automatic checkEntry(string req, logic [3:0] vec);
    logic [31:0] base;
    base = idtBase + 32'(vec) * 8;
    check("R1", "gate read count", 32'(nRd), 32'd2);
    check("R1", "gate low addr", rdAddr[0], base);
    check("R1", "gate high addr", rdAddr[1], base + 4);
    check("R4", "push count", 32'(nWr), 32'd5);
    for (int k = 0; k < 5; k++)
      check("R4", "push addr", wrAddr[k], tssEsp0 - 32'(4 * (k + 1)));
    check("R4", "push ss", wrData[0], {16'd0, curSs});
    check("R4", "push esp", wrData[1], curEsp);
    check("R4", "push flags", wrData[2], curFlags);
    check("R4", "push cs", wrData[3], {16'd0, curCs});
    check("R4", "push eip", wrData[4], curEip);
    check(req, "gp clear", 32'(sawGp), 32'd0);
    check("R6", "newEip", newEip, 32'h1000 + 32'(vec) * 16);
    check("R6", "newCs", 32'(newCs), 32'h8 + 32'(vec));
    check("R6", "newSs", 32'(newSs), 32'(tssSs0));
    check("R6", "newEsp", newEsp, tssEsp0 - 20);
    check("R6", "newCpl", 32'(newCpl), 32'd0);
    check("R6", "newFlags", newFlags, curFlags & ~32'h300);
    @(negedge clk);
    check("R8", "done one cycle", 32'(done), 32'd0);
    check("R8", "idle after done", 32'(busy), 32'd0);
  endtask

  task automatic testReset();
    check("R8", "reset busy", 32'(busy), 32'd0);
    check("R8", "reset done", 32'(done), 32'd0);
    check("R5", "reset memReq", 32'(memReq), 32'd0);
    check("R6", "reset newCpl", 32'(newCpl), 32'd0);
  endtask

  task automatic testSoftEqual();   // R2: cpl 3 == dpl 3 passes
    latency = 0;
    curCpl = 2'd3;
    launch(1'b0, 2'd0, 4'd3);
    waitDone();
    checkEntry("R2", 4'd3);
  endtask

  task automatic testReturn();      // R7: pops the frame just pushed
    latency = 1;
    curEsp = newEsp;
    launch(1'b1, 2'd0, 4'd0);
    waitDone();
    check("R7", "gp clear", 32'(sawGp), 32'd0);
    check("R7", "no writes", 32'(nWr), 32'd0);
    check("R7", "read count", 32'(nRd), 32'd5);
    for (int k = 0; k < 5; k++)
      check("R7", "pop addr", rdAddr[k], 32'h2EC + 32'(4 * k));
    check("R7", "eip", newEip, 32'h4000_1234);
    check("R7", "cs", 32'(newCs), 32'h001B);
    check("R7", "flags", newFlags, 32'h0000_0346);
    check("R7", "esp", newEsp, 32'h7FF0);
    check("R7", "ss", 32'(newSs), 32'h0023);
    check("R7", "cpl from cs", 32'(newCpl), 32'd3);
    curEsp = 32'h7FF0;
  endtask

  task automatic testPrivFault();   // R2/R3: cpl 3 > dpl 0 on software trap
    logic [31:0] eipB, flB, espB; logic [15:0] csB, ssB; logic [1:0] cplB;
    eipB = newEip; flB = newFlags; espB = newEsp; csB = newCs; ssB = newSs; cplB = newCpl;
    latency = 0;
    launch(1'b0, 2'd0, 4'd4);
    waitDone();
    check("R2", "gp raised", 32'(sawGp), 32'd1);
    check("R3", "no writes", 32'(nWr), 32'd0);
    check("R3", "eip kept", newEip, eipB);
    check("R3", "cs kept", 32'(newCs), 32'(csB));
    check("R3", "flags kept", newFlags, flB);
    check("R3", "esp kept", newEsp, espB);
    check("R3", "ss kept", 32'(newSs), 32'(ssB));
    check("R3", "cpl kept", 32'(newCpl), 32'(cplB));
    @(negedge clk);
    check("R3", "gp one cycle", 32'(gpFault), 32'd0);
  endtask

  task automatic testPageFault();   // R2/R5: fault ignores dpl 0, slow memory
    latency = 3;
    launch(1'b0, 2'd1, 4'd4);
    waitDone();
    checkEntry("R5", 4'd4);
  endtask

  task automatic testIrqTop();      // R1/R2: highest vector, external interrupt
    latency = 1;
    curCpl = 2'd2;
    launch(1'b0, 2'd2, 4'd15);
    waitDone();
    checkEntry("R2", 4'd15);
    curCpl = 2'd3;
  endtask

  task automatic testBusyIgnore();  // R8: second start while busy ignored
    latency = 2;
    launch(1'b0, 2'd0, 4'd3);
    @(negedge clk);
    vector = 4'd15; isReturn = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0; vector = 4'd3; isReturn = 1'b0;
    waitDone();
    checkEntry("R8", 4'd3);
    repeat (10) @(negedge clk);
    check("R8", "single done", 32'(nDone), 32'd1);
    check("R8", "no extra access", 32'(nRd + nWr), 32'd7);
  endtask

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = 32'd0;
    for (int v = 0; v < 16; v++) begin
      mem[64 + 2 * v] = 32'h1000 + 32'(v) * 16;
      mem[65 + 2 * v] = {14'd0, 2'(v % 4), 16'h8 + 16'(v)};
    end
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testSoftEqual();
    testReturn();
    testPrivFault();
    testPageFault();
    testIrqTop();
    testBusyIgnore();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule